// File: doc/BRIEF.md
# Range-steered radix-4 Booth multiplier

This block multiplies two 16-bit two's complement operands and returns the full 32-bit two's complement product. It is built to cut switching activity in the partial-product logic. Each operand is first measured for its effective dynamic range, meaning the number of bits left once the redundant leading sign copies are removed. The operand with the narrower range is steered into the radix-4 Booth recoder, and the other operand becomes the multiplicand. This makes it more likely that the upper Booth digits are zero.

Each Booth group has its own input register. A group whose digit is known to be zero for the current operand does not reload that register, so its recoding and selection logic keeps its old inputs and does not toggle. A registered activity flag forces the output of such a row to zero, which keeps the sum exact. The rows that remain are reduced column by column in a carry-save compressor tree, and a final carry-propagate adder gives the product.

The caller presents both operands with a one-cycle valid strobe. The product appears with its own valid flag on the following cycle and holds until the next strobe.

Top module: `drm_booth_mul`

## Requirements
- R1: The cycle after `in_valid` is sampled high, `product` equals the exact two's complement product of the sampled `op_a` and `op_b`, for every pair of 16-bit values including -32768 x -32768 (which gives 0x40000000).
- R2: `out_valid` is high in exactly the cycles that follow a cycle in which `in_valid` was sampled high, and is low otherwise.
- R3: While `in_valid` is low, the operand inputs are not captured: `product` keeps its last value whatever `op_a` and `op_b` do.
- R4: The effective range of an operand is 16 minus the number of leading bits, below bit 15, that equal bit 15. So 0 and -1 have range 1, 127 and -128 have range 8, 128 has range 9, and -32768 has range 16.
- R5: The operand with the smaller effective range is Booth-encoded. When the two ranges are equal, `op_a` is Booth-encoded. The product is the same either way.
- R6: Only the lowest ceil(range/2) Booth groups of the encoded operand reload their inputs on a strobe. Higher groups keep their previous register contents, contribute zero to the sum, and leave the product exact, including after a wide operand has been followed by a narrow one.
- R7: After reset, `out_valid` is 0 and `product` is 0.
- R8: Booth group i takes bits (2i+1, 2i, 2i-1) of the encoded operand, with bit -1 taken as 0. Triplets 000 and 111 give digit 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. Alternating and paired bit patterns therefore multiply exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand strobe; the operands are captured when it is high |
| op_a | input | 16 | First two's complement operand |
| op_b | input | 16 | Second two's complement operand |
| out_valid | output | 1 | High for one cycle with each new product |
| product | output | 32 | Two's complement product of the last captured operands |

## Verification
Most internal faults show up as a wrong `product` in the cycle right after a strobe. Examples are a wrong operand steering, a miscounted range that disables a group still carrying a nonzero digit, a wrong Booth triplet, or a carry lost in the compressor tree. The bench therefore compares every valid product against a behavioural signed multiply on every clock. It uses operand pairs whose ranges are narrow, wide, equal and at group boundaries. A frozen row that fails to contribute zero only shows when a narrow operand follows a wide one, so such sequences are placed back to back. Idle cycles with changing inputs expose any capture without a strobe within one cycle.

// File: rtl/drm_pkg.sv
package drm_pkg;
  // Decoded magnitude selection of one radix-4 Booth digit
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  function automatic booth_sel_t decode_triplet(input logic [2:0] t);
    booth_sel_t s;
    s.neg = t[2];
    s.one = t[1] ^ t[0];
    s.two = (t == 3'b011) || (t == 3'b100);
    return s;
  endfunction
endpackage

// File: rtl/drm_range_detect.sv
module drm_range_detect #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]          a_i,
  input  logic [W-1:0]          b_i,
  output logic [W-1:0]          enc_o,
  output logic [W-1:0]          mcand_o,
  output logic [$clog2(W+1)-1:0] rng_enc_o,
  output logic [$clog2(W+1)-1:0] rng_mcand_o,
  output logic [$clog2(W/2+1)-1:0] groups_o
);
  localparam int unsigned RW = $clog2(W + 1);
  localparam int unsigned GW = $clog2(W / 2 + 1);

  function automatic logic [RW-1:0] eff_range(input logic [W-1:0] x);
    logic [RW-1:0] red;
    logic          stop;
    red  = '0;
    stop = 1'b0;
    for (int i = W - 2; i >= 0; i--) begin
      if (!stop && (x[i] == x[W-1])) red = red + 1'b1;
      else stop = 1'b1;
    end
    return RW'(W) - red;
  endfunction

  logic [RW-1:0] rng_a, rng_b;
  logic          pick_b;
  logic [RW:0]   rng_up;

  always_comb begin
    rng_a  = eff_range(a_i);
    rng_b  = eff_range(b_i);
    pick_b = (rng_b < rng_a);
    enc_o       = pick_b ? b_i : a_i;
    mcand_o     = pick_b ? a_i : b_i;
    rng_enc_o   = pick_b ? rng_b : rng_a;
    rng_mcand_o = pick_b ? rng_a : rng_b;
    rng_up      = {1'b0, rng_enc_o} + 1'b1;
    groups_o    = GW'(rng_up >> 1);
  end
endmodule

// File: rtl/drm_pp_row.sv
module drm_pp_row
  import drm_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              active_i,
  input  logic [2:0]        trip_i,
  input  logic [W-1:0]      mcand_i,
  output logic [2*W-1:0]    pp_o
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned VW = W + 2;

  logic [2:0]   trip_q, trip_d;
  logic [W-1:0] mcand_q, mcand_d;
  logic         act_q, act_d;
  logic         load;

  booth_sel_t        sel;
  logic [W:0]        mag;
  logic [VW-1:0]     val;
  logic [PW-1:0]     ext;

  // next-state: reload operands only for groups inside the range
  always_comb begin
    load    = strobe_i && active_i;
    trip_d  = load ? trip_i : trip_q;
    mcand_d = load ? mcand_i : mcand_q;
    act_d   = strobe_i ? active_i : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q  <= '0;
      mcand_q <= '0;
      act_q   <= 1'b0;
    end else begin
      trip_q  <= trip_d;
      mcand_q <= mcand_d;
      act_q   <= act_d;
    end
  end

  always_comb begin
    sel = decode_triplet(trip_q);
    if (sel.one)      mag = {mcand_q[W-1], mcand_q};
    else if (sel.two) mag = {mcand_q, 1'b0};
    else              mag = '0;
    val = sel.neg ? (VW'(0) - {mag[W], mag}) : {mag[W], mag};
    ext = {{(PW-VW){val[VW-1]}}, val};
    pp_o = act_q ? (ext << (2 * IDX)) : '0;
  end

  // R6: a row outside the range keeps its operand registers frozen
  assert_row_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe_i && active_i) |=> ($stable(trip_q) && $stable(mcand_q)));
endmodule

// File: rtl/drm_csa_tree.sv
module drm_csa_tree #(
  parameter int unsigned PW = 32,
  parameter int unsigned N  = 8
) (
  input  logic [N-1:0][PW-1:0] rows_i,
  output logic [PW-1:0]        sum_o,
  output logic [PW-1:0]        carry_o
);
  logic [PW-1:0] cur [N];
  logic [PW-1:0] nxt [N];
  int            n, m;

  // repeated 3:2 column compression until two vectors remain
  always_comb begin
    for (int i = 0; i < N; i++) cur[i] = rows_i[i];
    for (int i = 0; i < N; i++) nxt[i] = '0;
    n = N;
    m = 0;
    for (int lvl = 0; lvl < N; lvl++) begin
      if (n > 2) begin
        m = 0;
        for (int i = 0; i < N; i++) nxt[i] = '0;
        for (int j = 0; j < N; j += 3) begin
          if (j + 2 < n) begin
            nxt[m]     = cur[j] ^ cur[j+1] ^ cur[j+2];
            nxt[m + 1] = ((cur[j] & cur[j+1]) | (cur[j] & cur[j+2]) |
                          (cur[j+1] & cur[j+2])) << 1;
            m = m + 2;
          end else if (j < n) begin
            nxt[m] = cur[j];
            m = m + 1;
            if (j + 1 < n) begin
              nxt[m] = cur[j+1];
              m = m + 1;
            end
          end
        end
        for (int i = 0; i < N; i++) cur[i] = (i < m) ? nxt[i] : '0;
        n = m;
      end
    end
    sum_o   = cur[0];
    carry_o = (N > 1) ? cur[1] : '0;
  end
endmodule

// File: rtl/drm_booth_mul.sv
module drm_booth_mul #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned NG = W / 2;
  localparam int unsigned RW = $clog2(W + 1);
  localparam int unsigned GW = $clog2(NG + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [W-1:0]  enc, mcand;
  logic [RW-1:0] rng_enc, rng_mcand;
  logic [GW-1:0] groups;
  logic [W:0]    enc_ext;

  drm_range_detect #(.W(W)) u_range (
    .a_i        (op_a),
    .b_i        (op_b),
    .enc_o      (enc),
    .mcand_o    (mcand),
    .rng_enc_o  (rng_enc),
    .rng_mcand_o(rng_mcand),
    .groups_o   (groups)
  );

  assign enc_ext = {enc, 1'b0};

  logic [NG-1:0][PW-1:0] rows;

  for (genvar g = 0; g < NG; g++) begin : g_row
    logic act;
    assign act = (GW'(g) < groups);
    drm_pp_row #(.W(W), .IDX(g)) u_row (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .strobe_i(in_valid),
      .active_i(act),
      .trip_i  (enc_ext[2*g +: 3]),
      .mcand_i (mcand),
      .pp_o    (rows[g])
    );
  end

  logic [PW-1:0] sum_v, carry_v;
  drm_csa_tree #(.PW(PW), .N(NG)) u_tree (
    .rows_i (rows),
    .sum_o  (sum_v),
    .carry_o(carry_v)
  );

  assign product = sum_v + carry_v;

  logic vld_d, vld_q;
  always_comb vld_d = in_valid;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= 1'b0;
    else          vld_q <= vld_d;
  end
  assign out_valid = vld_q;

  // behavioural reference used only by the assertions
  logic [PW-1:0] chk_mul;
  assign chk_mul = $signed({{W{op_a[W-1]}}, op_a}) * $signed({{W{op_b[W-1]}}, op_b});

  assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> (product == $past(chk_mul)));
  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  assert_valid_low_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> $stable(product));
  assert_group_bounds_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (groups >= GW'(1)) && (groups <= GW'(NG)) && (rng_enc >= RW'(1)));
  assert_narrow_encoded_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    rng_enc <= rng_mcand);
endmodule

// File: tb/drm_booth_mul_tb.sv
module drm_booth_mul_tb;
  localparam int W = 16;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  op_a, op_b;
  logic          out_valid;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit run_chk = 0;
  string cur_tag = "R1";

  // reference state
  bit            exp_valid = 0;
  logic [2*W-1:0] exp_prod = '0;
  string         exp_tag = "R1";

  drm_booth_mul #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint pa, pb, p;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    p  = pa * pb;
    return p[2*W-1:0];
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (run_chk) begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_prod <= ref_mul(op_a, op_b);
        exp_tag  <= cur_tag;
      end else begin
        exp_tag  <= "R3";
      end
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      checks++;
      if (out_valid !== exp_valid) begin
        errors++;
        $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, exp_valid);
      end
      checks++;
      if (product !== exp_prod) begin
        errors++;
        $display("FAIL %s product actual %h expected %h", exp_tag, product, exp_prod);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      op_a = W'($urandom);
      op_b = W'($urandom);
    end
  endtask

  function automatic logic [W-1:0] rnd_range();
    logic signed [W-1:0] v;
    v = W'($urandom);
    return v >>> $urandom_range(0, W - 1);
  endfunction

  initial begin
    in_valid = 0;
    op_a = '0;
    op_b = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state at the ports
    checks++;
    if (out_valid !== 1'b0 || product !== '0) begin
      errors++;
      $display("FAIL R7 reset actual %0b/%h expected 0/0", out_valid, product);
    end
    run_chk = 1;

    // R1 corners
    drive(16'h8000, 16'h8000, "R1");
    drive(16'h0000, 16'h7fff, "R1");
    drive(16'hffff, 16'h8000, "R1");
    drive(16'h0001, 16'h8001, "R1");
    drive(16'h7fff, 16'h7fff, "R1");
    drive(16'h8000, 16'h7fff, "R1");
    // R4 range boundaries
    drive(16'd127, 16'h1234, "R4");
    drive(16'hff80, 16'hedcb, "R4");
    drive(16'd128, 16'h0fff, "R4");
    drive(16'hffff, 16'h0000, "R4");
    // R5 steering: narrow on either side, and equal ranges
    drive(16'h7abc, 16'h0003, "R5");
    drive(16'h0003, 16'h7abc, "R5");
    drive(16'h00ff, 16'hff00, "R5");
    drive(16'hc000, 16'h4000, "R5");
    // R6 wide then narrow, back to back
    drive(16'h8000, 16'h9999, "R6");
    drive(16'h0002, 16'h8765, "R6");
    drive(16'h5a5a, 16'h6c6c, "R6");
    drive(16'hffff, 16'h6c6c, "R6");
    drive(16'h8001, 16'h7ffe, "R6");
    drive(16'h0001, 16'h0000, "R6");
    // R8 digit patterns
    drive(16'h5555, 16'haaaa, "R8");
    drive(16'h3333, 16'hcccc, "R8");
    drive(16'h6666, 16'h9999, "R8");
    drive(16'haaaa, 16'h7fff, "R8");
    // R3 idle with changing inputs, then resume
    idle(5);
    drive(16'h1357, 16'hfedc, "R3");
    idle(3);
    // random mixed ranges, with occasional gaps
    for (int k = 0; k < 400; k++) begin
      drive(rnd_range(), rnd_range(), "R1");
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
    end
    idle(3);
    run_chk = 0;
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule